// File: doc/BRIEF.md
# Sprite plane color-key compositor

This block merges two pixel streams, one beat per clock: each beat carries a sprite-plane pixel, the co-located primary-plane pixel and a format tag, and the block emits one composited pixel. The choice between the two is made by a color key. The key is made of a lower bound, a per-channel mask and an upper bound, together with a mode word that selects one of three behaviours. With keying off, the sprite always covers the primary. In source keying, sprite pixels that fall inside the key are transparent. In destination keying, primary pixels that equal the key are replaced by sprite pixels.

The key is written through a small register port into staging registers. It is copied to the active set only on a frame-start strobe, so one frame is always composited with one key. The pixel path is a single register stage with valid/ready handshakes on both sides.

Pixels are `NCH` channels of `CH_W` bits each, with channel c at bits [c*CH_W+CH_W-1 : c*CH_W]. The defaults are three channels of 8 bits.

Top module: `sprite_ckey_comp`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1 and cfg_err_o is 0. The active mode is "keying off" and the active min, mask and max are all zero.
- R2: With keying off (mode word 3'b001, or 3'b000), every output pixel is the sprite pixel.
- R3: Source keying applies to a YUV beat (fmt_i = 1). The primary pixel is output when, for every channel, (min & mask) <= (sprite & mask) <= (max & mask), with both bounds inclusive. Otherwise the sprite pixel is output.
- R4: Source keying applies to an RGB beat (fmt_i = 0). The test is masked equality (sprite & mask) == (min & mask) and max is not used. On a match the primary pixel is output, otherwise the sprite pixel.
- R5: In destination keying, for either format, the sprite pixel is output when (primary & mask) == (min & mask). Otherwise the primary pixel is output.
- R6: Mask bits that are zero take no part in the compare. With an all-zero mask, every pixel matches.
- R7: The configuration registers are at cfg_addr_i 0 = min, 1 = mask, 2 = max and 3 = mode. In the mode word, bit 0 means keying off, bit 1 means destination keying and bit 2 means source keying. A mode write with more than one of bits [2:0] set is rejected: cfg_err_o is 1 for the one cycle after that write, and the staged mode keeps its old value.
- R8: Writes go to staging registers. They are copied to the active key on a clock edge at which frame_start_i is 1. A beat accepted at that same edge still uses the old key.
- R9: A beat accepted at a clock edge (in_valid_i and in_ready_o both 1) appears on out_pix_o after that edge, with out_valid_o at 1 and out_fmt_o equal to the beat's fmt_i.
- R10: While out_valid_o is 1 and out_ready_i is 0, in_ready_o is 0 and out_pix_o and out_fmt_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | NCH*CH_W | Configuration write data |
| frame_start_i | input | 1 | Frame-start strobe; loads the staged key |
| cfg_err_o | output | 1 | Rejected mode write, one-cycle pulse |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted |
| spr_pix_i | input | NCH*CH_W | Sprite-plane pixel |
| pri_pix_i | input | NCH*CH_W | Primary-plane pixel |
| fmt_i | input | 1 | Surface format, 0 = RGB, 1 = YUV |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_pix_o | output | NCH*CH_W | Composited pixel |
| out_fmt_o | output | 1 | Format tag of the output beat |

## Verification
The hardest cases to reach are those where key timing and the handshake meet. One is a beat that enters in the very cycle that the frame strobe swaps the key. Another is a second beat that waits while the output is stalled. The stimulus stages a key that would flip the result, raises the strobe together with a beat, and then checks that this beat still follows the old key while the next beat follows the new one. The main sweep walks every channel across values just below, at, between and just above the bounds, for each mode, each format and full, partial and empty masks.

// File: rtl/ckey_pkg.sv
package ckey_pkg;
  typedef enum logic {FMT_RGB = 1'b0, FMT_YUV = 1'b1} pix_fmt_e;
  typedef enum logic [1:0] {
    REG_MIN  = 2'd0,
    REG_MASK = 2'd1,
    REG_MAX  = 2'd2,
    REG_MODE = 2'd3
  } cfg_reg_e;
  localparam int MODE_W   = 3;
  localparam int MODE_OFF = 0;
  localparam int MODE_DST = 1;
  localparam int MODE_SRC = 2;
  localparam logic [MODE_W-1:0] MODE_RESET = 3'b001;
endpackage

// File: rtl/ckey_cfg.sv
module ckey_cfg
  import ckey_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           addr_i,
  input  logic [PIX_W-1:0]     wdata_i,
  input  logic                 frame_start_i,
  output logic [PIX_W-1:0]     act_min_o,
  output logic [PIX_W-1:0]     act_mask_o,
  output logic [PIX_W-1:0]     act_max_o,
  output logic [MODE_W-1:0]    act_mode_o,
  output logic                 err_o
);
  logic [PIX_W-1:0]  stg_min, stg_mask, stg_max;
  logic [MODE_W-1:0] stg_mode, new_mode;
  logic              mode_wr, mode_bad;

  assign new_mode = wdata_i[MODE_W-1:0];
  assign mode_wr  = we_i && (addr_i == REG_MODE);
  // more than one mode bit set
  assign mode_bad = (new_mode[0] & new_mode[1]) | (new_mode[0] & new_mode[2]) |
                    (new_mode[1] & new_mode[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_min  <= '0;
      stg_mask <= '0;
      stg_max  <= '0;
      stg_mode <= MODE_RESET;
      err_o    <= 1'b0;
    end else begin
      err_o <= mode_wr && mode_bad;
      if (we_i) begin
        unique case (addr_i)
          REG_MIN:  stg_min  <= wdata_i;
          REG_MASK: stg_mask <= wdata_i;
          REG_MAX:  stg_max  <= wdata_i;
          default:  if (!mode_bad) stg_mode <= new_mode;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_min_o  <= '0;
      act_mask_o <= '0;
      act_max_o  <= '0;
      act_mode_o <= MODE_RESET;
    end else if (frame_start_i) begin
      act_min_o  <= stg_min;
      act_mask_o <= stg_mask;
      act_max_o  <= stg_max;
      act_mode_o <= stg_mode;
    end
  end
endmodule

// File: rtl/ckey_match.sv
module ckey_match #(
  parameter int CH_W = 8,
  parameter int NCH  = 3,
  localparam int PIX_W = CH_W * NCH
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] kmin_i,
  input  logic [PIX_W-1:0] kmask_i,
  input  logic [PIX_W-1:0] kmax_i,
  input  logic             range_en_i,
  output logic             hit_o
);
  logic [NCH-1:0] ch_hit;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CH_W-1:0] m, v, lo, hi;
    assign m  = kmask_i[c*CH_W +: CH_W];
    assign v  = pix_i[c*CH_W +: CH_W] & m;
    assign lo = kmin_i[c*CH_W +: CH_W] & m;
    assign hi = kmax_i[c*CH_W +: CH_W] & m;
    assign ch_hit[c] = range_en_i ? ((v >= lo) && (v <= hi)) : (v == lo);
  end

  assign hit_o = &ch_hit;
endmodule

// File: rtl/sprite_ckey_comp.sv
module sprite_ckey_comp
  import ckey_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int NCH  = 3,
  localparam int PIX_W = CH_W * NCH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [PIX_W-1:0] cfg_wdata_i,
  input  logic             frame_start_i,
  output logic             cfg_err_o,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PIX_W-1:0] spr_pix_i,
  input  logic [PIX_W-1:0] pri_pix_i,
  input  logic             fmt_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PIX_W-1:0] out_pix_o,
  output logic             out_fmt_o
);
  logic [PIX_W-1:0]  act_min, act_mask, act_max, sel_pix;
  logic [MODE_W-1:0] act_mode;
  logic              spr_hit, pri_hit, accept;

  ckey_cfg #(.PIX_W(PIX_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i          (cfg_we_i),
    .addr_i        (cfg_addr_i),
    .wdata_i       (cfg_wdata_i),
    .frame_start_i (frame_start_i),
    .act_min_o     (act_min),
    .act_mask_o    (act_mask),
    .act_max_o     (act_max),
    .act_mode_o    (act_mode),
    .err_o         (cfg_err_o)
  );

  // source key: range on YUV, equality on RGB
  ckey_match #(.CH_W(CH_W), .NCH(NCH)) u_spr_match (
    .pix_i (spr_pix_i), .kmin_i (act_min), .kmask_i (act_mask), .kmax_i (act_max),
    .range_en_i (fmt_i == FMT_YUV), .hit_o (spr_hit)
  );

  // destination key: always equality
  ckey_match #(.CH_W(CH_W), .NCH(NCH)) u_pri_match (
    .pix_i (pri_pix_i), .kmin_i (act_min), .kmask_i (act_mask), .kmax_i (act_max),
    .range_en_i (1'b0), .hit_o (pri_hit)
  );

  always_comb begin
    if (act_mode[MODE_SRC])      sel_pix = spr_hit ? pri_pix_i : spr_pix_i;
    else if (act_mode[MODE_DST]) sel_pix = pri_hit ? spr_pix_i : pri_pix_i;
    else                         sel_pix = spr_pix_i;
  end

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
      out_fmt_o   <= 1'b0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
      out_pix_o   <= sel_pix;
      out_fmt_o   <= fmt_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ckey_chk.sv
module ckey_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [1:0]       cfg_addr_i,
  input logic [PIX_W-1:0] cfg_wdata_i,
  input logic             frame_start_i,
  input logic             cfg_err_o,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [PIX_W-1:0] spr_pix_i,
  input logic [PIX_W-1:0] pri_pix_i,
  input logic             fmt_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [PIX_W-1:0] out_pix_o,
  input logic             out_fmt_o,
  input logic [2:0]       act_mode
);
  logic bad_mode_wr;
  assign bad_mode_wr = cfg_we_i && (cfg_addr_i == 2'd3) && ($countones(cfg_wdata_i[2:0]) > 1);

  assert_latency_one_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o && (out_fmt_o == $past(fmt_i)));

  assert_pick_input_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> (out_pix_o == $past(spr_pix_i)) || (out_pix_o == $past(pri_pix_i)));

  assert_hold_on_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o) && $stable(out_fmt_o));

  assert_no_accept_on_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  assert_err_on_bad_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_mode_wr |=> cfg_err_o);

  assert_err_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_mode_wr |=> !cfg_err_o);

  assert_modes_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_mode));

  assert_key_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_mode));
endmodule

bind sprite_ckey_comp ckey_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_addr_i    (cfg_addr_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .frame_start_i (frame_start_i),
  .cfg_err_o     (cfg_err_o),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .spr_pix_i     (spr_pix_i),
  .pri_pix_i     (pri_pix_i),
  .fmt_i         (fmt_i),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_pix_o     (out_pix_o),
  .out_fmt_o     (out_fmt_o),
  .act_mode      (act_mode)
);

// File: tb/sim_sprite_ckey_comp.sv
module sim_sprite_ckey_comp;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W = 8;
  localparam int NCH  = 3;
  localparam int PIX_W = CH_W * NCH;

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0, frame_start_i = 1'b0;
  logic [1:0]       cfg_addr_i = '0;
  logic [PIX_W-1:0] cfg_wdata_i = '0;
  logic             cfg_err_o;
  logic             in_valid_i = 1'b0, in_ready_o;
  logic [PIX_W-1:0] spr_pix_i = '0, pri_pix_i = '0;
  logic             fmt_i = 1'b0;
  logic             out_valid_o, out_ready_i = 1'b1, out_fmt_o;
  logic [PIX_W-1:0] out_pix_o;

  int checks = 0, errors = 0;
  bit done = 0;

  sprite_ckey_comp #(.CH_W(CH_W), .NCH(NCH)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(bit ok, string req, logic [PIX_W-1:0] act, logic [PIX_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side key model
  function automatic logic [PIX_W-1:0] model(logic [2:0] mode, logic [PIX_W-1:0] kmin,
      logic [PIX_W-1:0] kmask, logic [PIX_W-1:0] kmax, logic [PIX_W-1:0] spr,
      logic [PIX_W-1:0] pri, logic fmt);
    bit s_ok = 1, p_ok = 1;
    for (int c = 0; c < NCH; c++) begin
      int m  = kmask[c*CH_W +: CH_W];
      int lo = kmin[c*CH_W +: CH_W] & m;
      int hi = kmax[c*CH_W +: CH_W] & m;
      int sv = spr[c*CH_W +: CH_W] & m;
      int pv = pri[c*CH_W +: CH_W] & m;
      if (fmt) begin if (sv < lo || sv > hi) s_ok = 0; end
      else if (sv != lo) s_ok = 0;
      if (pv != lo) p_ok = 0;
    end
    if (mode[2]) return s_ok ? pri : spr;
    if (mode[1]) return p_ok ? spr : pri;
    return spr;
  endfunction

  task automatic wr(logic [1:0] a, logic [PIX_W-1:0] d);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic strobe();
    frame_start_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    frame_start_i = 0;
  endtask

  task automatic push(logic [PIX_W-1:0] s, logic [PIX_W-1:0] p, logic f,
                      logic [PIX_W-1:0] exp, string req);
    in_valid_i = 1; spr_pix_i = s; pri_pix_i = p; fmt_i = f;
    @(posedge clk_i); @(negedge clk_i);
    in_valid_i = 0;
    chk(out_valid_o === 1'b1 && out_pix_o === exp && out_fmt_o === f, req, out_pix_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] modes [3] = '{3'b001, 3'b010, 3'b100};
    logic [PIX_W-1:0] masks [4] = '{24'hFFFFFF, 24'h00FF00, 24'h000000, 24'hF0F00F};
    logic [7:0] vals [5] = '{8'h3F, 8'h40, 8'h60, 8'h80, 8'h81};
    logic [PIX_W-1:0] kmin = 24'h404040, kmax = 24'h808080;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(out_valid_o === 0, "R1 out_valid", {23'b0, out_valid_o}, 0);
    chk(in_ready_o === 1, "R1 in_ready", {23'b0, in_ready_o}, 1);
    chk(cfg_err_o === 0, "R1 cfg_err", {23'b0, cfg_err_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(out_valid_o === 0 && in_ready_o === 1, "R1 after release", {23'b0, out_valid_o}, 0);
    push(24'h112233, 24'h445566, 0, 24'h112233, "R1 reset mode off");

    // R8: staged key without a strobe is not used
    wr(2'd1, 24'h000000);
    wr(2'd3, 24'h000004);
    push(24'h0A0B0C, 24'h0D0E0F, 1, 24'h0A0B0C, "R8 staged not active");
    // R8: beat on the strobe edge still uses the old key
    frame_start_i = 1; in_valid_i = 1; spr_pix_i = 24'h0A0B0C; pri_pix_i = 24'h0D0E0F; fmt_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    frame_start_i = 0; in_valid_i = 0;
    chk(out_pix_o === 24'h0A0B0C, "R8 same-edge beat", out_pix_o, 24'h0A0B0C);
    push(24'h0A0B0C, 24'h0D0E0F, 1, 24'h0D0E0F, "R8 R6 key active zero mask");

    // R7 rejected mode write keeps source keying
    wr(2'd3, 24'h000006);
    chk(cfg_err_o === 1, "R7 err pulse", {23'b0, cfg_err_o}, 1);
    @(negedge clk_i);
    chk(cfg_err_o === 0, "R7 err clears", {23'b0, cfg_err_o}, 0);
    strobe();
    push(24'h0A0B0C, 24'h0D0E0F, 0, 24'h0D0E0F, "R7 old mode kept");
    wr(2'd3, 24'h000000);
    chk(cfg_err_o === 0, "R7 zero mode accepted", {23'b0, cfg_err_o}, 0);
    strobe();
    push(24'h0A0B0C, 24'h0D0E0F, 1, 24'h0A0B0C, "R2 zero mode is off");

    // R4 max ignored on RGB, used on YUV
    wr(2'd0, 24'h404040); wr(2'd1, 24'hFFFFFF); wr(2'd2, 24'h000000); wr(2'd3, 24'h000004);
    strobe();
    push(24'h404040, 24'h999999, 0, 24'h999999, "R4 rgb equality ignores max");
    push(24'h404040, 24'h999999, 1, 24'h404040, "R3 yuv empty range");

    // R10 stall
    wr(2'd3, 24'h000001); strobe();
    out_ready_i = 0;
    push(24'h010203, 24'h040506, 0, 24'h010203, "R9 first beat");
    in_valid_i = 1; spr_pix_i = 24'h070809; fmt_i = 1;
    chk(in_ready_o === 0, "R10 in_ready low", {23'b0, in_ready_o}, 0);
    @(posedge clk_i); @(negedge clk_i);
    chk(out_pix_o === 24'h010203 && out_fmt_o === 0 && out_valid_o === 1, "R10 hold", out_pix_o, 24'h010203);
    out_ready_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    in_valid_i = 0;
    chk(out_pix_o === 24'h070809 && out_fmt_o === 1, "R9 R10 second beat", out_pix_o, 24'h070809);
    @(negedge clk_i);
    chk(out_valid_o === 0, "R9 drains", {23'b0, out_valid_o}, 0);

    // sweep over modes, formats, masks and boundary values
    wr(2'd0, kmin); wr(2'd2, kmax);
    foreach (modes[mi]) foreach (masks[ki]) for (int f = 0; f < 2; f++) begin
      string req;
      wr(2'd1, masks[ki]); wr(2'd3, {21'b0, modes[mi]}); strobe();
      if (modes[mi][2]) req = f ? "R3 src yuv" : "R4 src rgb";
      else if (modes[mi][1]) req = "R5 dst";
      else req = "R2 off";
      if (masks[ki] != 24'hFFFFFF) req = {req, " R6 mask"};
      for (int a = 0; a < 5; a++) for (int b = 0; b < 5; b++) for (int c = 0; c < 5; c++) begin
        logic [PIX_W-1:0] v = {vals[a], vals[b], vals[c]};
        logic [PIX_W-1:0] s = modes[mi][1] ? 24'hABCDEF : v;
        logic [PIX_W-1:0] p = modes[mi][1] ? v : 24'h123456;
        push(s, p, f[0], model(modes[mi], kmin, masks[ki], kmax, s, p, f[0]), req);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule